// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA

This engine sends frames that software has queued as a linked list of descriptors in system memory. Each descriptor is four little-endian 32-bit words, 16-byte aligned. Word 0 holds flags, word 1 the start address of the frame buffer, word 2 the frame length and completion status, and word 3 the address of the next descriptor. Software fills the list, marks the descriptors it wants sent as engine-owned, raises `tx_on` and pulses `poll`. The engine fetches each owned descriptor, reads the buffer over a single memory-master port and emits the bytes on a byte stream with valid, ready and last. It then writes the completion status back, returns the descriptor to software and moves to the next one.

When the engine reaches a descriptor that software still owns, it signals descriptor-unavailable and stops. The current-descriptor output keeps that descriptor's address. After software hands more descriptors over, a further `poll` pulse makes the engine fetch the same descriptor again and carry on down the chain.

The controller is a state machine with these states:
- `S_IDLE`: waits for `tx_on` together with `poll`, then goes to `S_FLG_RQ`.
- `S_FLG_RQ` / `S_FLG_WT`: read word 0. If the descriptor is engine-owned the machine goes to `S_BUF_RQ`. If it is CPU-owned it signals descriptor-unavailable and returns to `S_IDLE`.
- `S_BUF_RQ` / `S_BUF_WT`: read word 1.
- `S_LEN_RQ` / `S_LEN_WT`: read word 2.
- `S_NXT_RQ` / `S_NXT_WT`: read word 3 and load the byte streamer, then go to `S_STREAM`.
- `S_STREAM`: goes to `S_DAT_RQ` when the streamer needs a buffer word, and to `S_WB_STAT` once all bytes have left.
- `S_DAT_RQ` / `S_DAT_WT`: fetch one buffer word, then return to `S_STREAM`.
- `S_WB_STAT`: writes word 2, then goes to `S_WB_FLG`.
- `S_WB_FLG`: writes word 0, raises the completion events and goes back to `S_FLG_RQ` at the next descriptor.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the engine is idle. `mem_req`, `tx_valid` and all three event outputs are low, and `cur_desc` and `cur_buf` are zero.
- R2: A `poll` pulse starts the engine only while `tx_on` is high. A pulse seen with `tx_on` low causes no memory request and no stream output.
- R3: For each descriptor the engine reads word 0 at offset 0, word 1 at offset 4, word 2 at offset 8 and word 3 at offset 12. Bit 31 of word 0 is the owner (1 = engine, 0 = CPU) and bit 2 is the interrupt enable. The length is bits 15:0 of word 2, and after completion the engine moves on to the address held in word 3.
- R4: The engine emits exactly `length` bytes starting at the buffer address. The buffer may start at any byte offset. Byte k of a memory word is bits 8k+7:8k. `tx_last` marks the final byte, and data and last hold steady while `tx_ready` is low.
- R5: A descriptor with length zero emits no bytes but is still written back and completed.
- R6: After a frame the engine writes word 2 first, with bits 15:0 = length, bit 19 = 1, bit 16 = the interrupt-enable bit and all other bits 0. It then writes word 0 with bit 31 cleared and every other flag bit kept.
- R7: Each completed descriptor raises `ev_complete` and `ev_summary` for exactly one cycle.
- R8: Finding a CPU-owned descriptor raises `ev_unavail` for one cycle and halts the engine. `cur_desc` then holds that descriptor's address and no write is made to it.
- R9: A `poll` pulse after a halt fetches the same descriptor's word 0 again and resumes the chain from there.
- R10: If `tx_on` is low while the engine is idle, the next start begins at `list_base`. Otherwise a start continues at `cur_desc`.
- R11: `cur_buf` takes a descriptor's buffer address when word 1 is read, and keeps it until the next descriptor's word 1.
- R12: Every memory request is word-aligned and keeps its address, direction and write data until it is granted. Each completed descriptor costs exactly two write transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_on | input | 1 | Transmit enable level |
| poll | input | 1 | Poll-demand pulse |
| list_base | input | ADDR_W | Address of the first descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word-aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid (after the grant) |
| mem_rdata | input | 32 | Read data |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| cur_desc | output | ADDR_W | Address of the current descriptor |
| cur_buf | output | ADDR_W | Buffer address of the current descriptor |
| ev_complete | output | 1 | Frame-complete event pulse |
| ev_summary | output | 1 | Transmit summary event pulse |
| ev_unavail | output | 1 | Descriptor-unavailable event pulse |

## Verification
The bench goes after several corner cases, each with a clear failure signature:
- Buffers starting at byte offsets 6 and 0x3F: a wrong lane pointer would shuffle or drop bytes at word boundaries.
- A zero-length descriptor: a naive streamer would emit a byte or lock up.
- Stale status bits placed in word 2: these must come back cleared, and the interrupt bit must follow each descriptor's own enable.
- A halt followed by a re-poll after software flips the owner bit: an engine that advanced past the CPU-owned descriptor would skip it.
- A `tx_on` drop between runs: an engine that ignored it would not restart at the new list base.
- Random grant and ready stalls: these expose requests or bytes that change before they are accepted.

// File: rtl/txd_pkg.sv
package txd_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int LANES    = WORD_W / BYTE_W;
    localparam int LANE_W   = $clog2(LANES);

    // bit positions software and hardware agree on
    localparam int OWN_BIT  = 31;
    localparam int IEN_BIT  = 2;
    localparam int DONE_BIT = 19;
    localparam int IRQ_BIT  = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FLG_RQ, S_FLG_WT,
        S_BUF_RQ, S_BUF_WT,
        S_LEN_RQ, S_LEN_WT,
        S_NXT_RQ, S_NXT_WT,
        S_STREAM,
        S_DAT_RQ, S_DAT_WT,
        S_WB_STAT, S_WB_FLG
    } txd_state_e;

endpackage

// File: rtl/txd_stream.sv
module txd_stream
    import txd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic [LEN_W-1:0]     init_len,
    input  logic [LANE_W-1:0]    init_lane,
    input  logic                 load,
    input  logic [WORD_W-1:0]    load_word,
    input  logic                 tx_ready,
    output logic [BYTE_W-1:0]    tx_data,
    output logic                 tx_valid,
    output logic                 tx_last,
    output logic                 need_word,
    output logic                 empty
);

    localparam logic [LEN_W-1:0]  ONE_B    = LEN_W'(1);
    localparam logic [LANE_W-1:0] LAST_LN  = LANE_W'(LANES - 1);

    logic [LEN_W-1:0]  rem_q;
    logic [LANE_W-1:0] lane_q;
    logic [WORD_W-1:0] word_q;
    logic              have_q;
    logic              fire;

    assign fire = have_q & tx_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            lane_q <= '0;
            word_q <= '0;
            have_q <= 1'b0;
        end else if (init) begin
            rem_q  <= init_len;
            lane_q <= init_lane;
            have_q <= 1'b0;
        end else begin
            if (load) begin
                word_q <= load_word;
                have_q <= 1'b1;
            end
            if (fire) begin
                rem_q  <= rem_q - ONE_B;
                lane_q <= lane_q + 1'b1;
                if (lane_q == LAST_LN || rem_q == ONE_B)
                    have_q <= 1'b0;
            end
        end
    end

    assign tx_data   = word_q[BYTE_W*lane_q +: BYTE_W];
    assign tx_valid  = have_q;
    assign tx_last   = have_q && (rem_q == ONE_B);
    assign need_word = !have_q && (rem_q != '0);
    assign empty     = (rem_q == '0);

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_on,
    input  logic                 poll,
    input  logic [ADDR_W-1:0]    list_base,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [WORD_W-1:0]    mem_wdata,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 st_init,
    output logic [LEN_W-1:0]     st_len,
    output logic [LANE_W-1:0]    st_lane,
    output logic                 st_load,
    input  logic                 st_need,
    input  logic                 st_empty,
    output logic [ADDR_W-1:0]    cur_desc,
    output logic [ADDR_W-1:0]    cur_buf,
    output logic                 ev_done,
    output logic                 ev_unavail
);

    localparam logic [ADDR_W-1:0] OFS_BUF = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_LEN = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_NXT = ADDR_W'(12);
    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(LANES);

    txd_state_e state_q, state_d;

    logic [ADDR_W-1:0] desc_q, buf_q, nxt_q, dptr_q;
    logic [WORD_W-1:0] flg_q;
    logic [LEN_W-1:0]  len_q;
    logic              primed_q;
    logic              done_q, unav_q;
    logic              start;

    assign start = tx_on && poll;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start)      state_d = S_FLG_RQ;
            S_FLG_RQ:  if (mem_gnt)    state_d = S_FLG_WT;
            S_FLG_WT:  if (mem_rvalid) state_d = mem_rdata[OWN_BIT] ? S_BUF_RQ : S_IDLE;
            S_BUF_RQ:  if (mem_gnt)    state_d = S_BUF_WT;
            S_BUF_WT:  if (mem_rvalid) state_d = S_LEN_RQ;
            S_LEN_RQ:  if (mem_gnt)    state_d = S_LEN_WT;
            S_LEN_WT:  if (mem_rvalid) state_d = S_NXT_RQ;
            S_NXT_RQ:  if (mem_gnt)    state_d = S_NXT_WT;
            S_NXT_WT:  if (mem_rvalid) state_d = S_STREAM;
            S_STREAM: begin
                if (st_empty)          state_d = S_WB_STAT;
                else if (st_need)      state_d = S_DAT_RQ;
            end
            S_DAT_RQ:  if (mem_gnt)    state_d = S_DAT_WT;
            S_DAT_WT:  if (mem_rvalid) state_d = S_STREAM;
            S_WB_STAT: if (mem_gnt)    state_d = S_WB_FLG;
            S_WB_FLG:  if (mem_gnt)    state_d = S_FLG_RQ;
            default:                   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_q;
        mem_wdata = '0;
        unique case (state_q)
            S_FLG_RQ:  mem_req = 1'b1;
            S_BUF_RQ: begin mem_req = 1'b1; mem_addr = desc_q + OFS_BUF; end
            S_LEN_RQ: begin mem_req = 1'b1; mem_addr = desc_q + OFS_LEN; end
            S_NXT_RQ: begin mem_req = 1'b1; mem_addr = desc_q + OFS_NXT; end
            S_DAT_RQ: begin mem_req = 1'b1; mem_addr = dptr_q; end
            S_WB_STAT: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = desc_q + OFS_LEN;
                mem_wdata[LEN_W-1:0] = len_q;
                mem_wdata[DONE_BIT]  = 1'b1;
                mem_wdata[IRQ_BIT]   = flg_q[IEN_BIT];
            end
            S_WB_FLG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = flg_q;
                mem_wdata[OWN_BIT] = 1'b0;
            end
            default: ;
        endcase
        st_init = (state_q == S_NXT_WT) && mem_rvalid;
        st_load = (state_q == S_DAT_WT) && mem_rvalid;
    end

    // descriptor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_q   <= '0;
            buf_q    <= '0;
            nxt_q    <= '0;
            dptr_q   <= '0;
            flg_q    <= '0;
            len_q    <= '0;
            primed_q <= 1'b0;
            done_q   <= 1'b0;
            unav_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unav_q <= 1'b0;
            if (state_q == S_IDLE) begin
                if (start) begin
                    if (!primed_q) desc_q <= list_base;
                    primed_q <= 1'b1;
                end else if (!tx_on) begin
                    primed_q <= 1'b0;
                end
            end
            if (mem_rvalid) begin
                unique case (state_q)
                    S_FLG_WT: begin
                        flg_q  <= mem_rdata;
                        unav_q <= !mem_rdata[OWN_BIT];
                    end
                    S_BUF_WT: begin
                        buf_q  <= mem_rdata;
                        dptr_q <= {mem_rdata[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                    end
                    S_LEN_WT: len_q  <= mem_rdata[LEN_W-1:0];
                    S_NXT_WT: nxt_q  <= mem_rdata;
                    S_DAT_WT: dptr_q <= dptr_q + STEP;
                    default: ;
                endcase
            end
            if (state_q == S_WB_FLG && mem_gnt) begin
                desc_q <= nxt_q;
                done_q <= 1'b1;
            end
        end
    end

    assign st_len     = len_q;
    assign st_lane    = buf_q[LANE_W-1:0];
    assign cur_desc   = desc_q;
    assign cur_buf    = buf_q;
    assign ev_done    = done_q;
    assign ev_unavail = unav_q;

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_on,
    input  logic              poll,
    input  logic [ADDR_W-1:0] list_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] cur_desc,
    output logic [ADDR_W-1:0] cur_buf,
    output logic              ev_complete,
    output logic              ev_summary,
    output logic              ev_unavail
);

    logic              st_init, st_load, st_need, st_empty, ev_done;
    logic [LEN_W-1:0]  st_len;
    logic [LANE_W-1:0] st_lane;

    txd_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_on      (tx_on),
        .poll       (poll),
        .list_base  (list_base),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .st_init    (st_init),
        .st_len     (st_len),
        .st_lane    (st_lane),
        .st_load    (st_load),
        .st_need    (st_need),
        .st_empty   (st_empty),
        .cur_desc   (cur_desc),
        .cur_buf    (cur_buf),
        .ev_done    (ev_done),
        .ev_unavail (ev_unavail)
    );

    txd_stream #(.LEN_W(LEN_W)) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (st_init),
        .init_len  (st_len),
        .init_lane (st_lane),
        .load      (st_load),
        .load_word (mem_rdata),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .need_word (st_need),
        .empty     (st_empty)
    );

    assign ev_complete = ev_done;
    assign ev_summary  = ev_done;

endmodule

// File: rtl/txdesc_dma_sva.sv
module txdesc_dma_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_last,
    input logic              ev_complete,
    input logic              ev_unavail,
    input logic [ADDR_W-5:0] desc_hi
);

    // R12: request fields hold until granted
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R12: word-aligned accesses only
    a_r12_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R4: byte and last flag steady under back-pressure
    a_r4_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R6: the flag write-back always returns ownership
    a_r6_owner_release: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr[3:2] == 2'd0 |-> !mem_wdata[31]);

    // R6: write-backs target only words 0 and 2 of the current descriptor
    a_r6_wb_target: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr[ADDR_W-1:4] == desc_hi && !mem_addr[2]);

    // R8: completion and unavailable never in the same cycle
    a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_complete, ev_unavail}));

endmodule

bind txdesc_dma txdesc_dma_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_gnt     (mem_gnt),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .ev_complete (ev_complete),
    .ev_unavail  (ev_unavail),
    .desc_hi     (cur_desc[ADDR_W-1:4])
);

// File: tb/test_txdesc_dma.sv
`timescale 1ns/1ps
module test_txdesc_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_on = 1'b0;
    logic        poll = 1'b0;
    logic [31:0] list_base = 32'h100;
    logic        mem_req, mem_we, mem_gnt;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last, tx_ready;
    logic [31:0] cur_desc, cur_buf;
    logic        ev_complete, ev_summary, ev_unavail;

    always #2.5 clk = ~clk;

    txdesc_dma i_txdesc_dma (
        .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .poll(poll), .list_base(list_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .cur_desc(cur_desc), .cur_buf(cur_buf),
        .ev_complete(ev_complete), .ev_summary(ev_summary), .ev_unavail(ev_unavail)
    );

    // memory model with pseudo-random stalls
    logic [31:0] mem [0:255];
    logic [15:0] lfsr = 16'hACE1;
    assign mem_gnt  = mem_req & (lfsr[0] | lfsr[3]);
    assign tx_ready = lfsr[5] | lfsr[9];

    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_rvalid <= 1'b0;
        if (mem_req && mem_gnt) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[9:2]];
            end
        end
    end

    int nvec = 0, nerr = 0;
    int n_cmp = 0, n_sum = 0, n_unav = 0, n_wr = 0, req_cyc = 0;
    logic [7:0] exp_b[$];
    logic       exp_l[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // reference stream: expected bytes of a frame, little-endian lanes
    task automatic add_frame(input int base, input int len);
        for (int i = 0; i < len; i++) begin
            int a = base + i;
            exp_b.push_back(mem[(a >> 2) & 255][8*(a & 3) +: 8]);
            exp_l.push_back(i == len - 1);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        mem[(a >> 2) & 255] <= v;
    endtask

    task automatic pulse_poll();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
    endtask

    task automatic wait_unav(input int target);
        while (n_unav < target) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_complete) n_cmp++;
            if (ev_summary)  n_sum++;
            if (ev_unavail)  n_unav++;
            if (mem_req) req_cyc++;
            if (mem_req && mem_gnt && mem_we) n_wr++;
            if (tx_valid && tx_ready) begin
                if (exp_b.size() == 0) chk("R4 unexpected byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
                else begin
                    chk("R4 byte", {24'd0, tx_data}, {24'd0, exp_b.pop_front()});
                    chk("R4 last", {31'd0, tx_last}, {31'd0, exp_l.pop_front()});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        for (int i = 0; i < 32; i++) mem[128 + i] = 32'h1357_9BDF * (i + 1) + 32'h0246_8ACE;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 0);
        chk("R1 cur_desc", cur_desc, 0);
        chk("R1 cur_buf", cur_buf, 0);
        chk("R1 events", {29'd0, ev_complete, ev_summary, ev_unavail}, 0);
        rst_n = 1'b1;

        // chain: two owned descriptors then one CPU-owned
        wr(32'h100, 32'h8000_0014); wr(32'h104, 32'h200); wr(32'h108, 32'h00A0_0006); wr(32'h10C, 32'h110);
        wr(32'h110, 32'h8000_0000); wr(32'h114, 32'h206); wr(32'h118, 32'h0000_0011); wr(32'h11C, 32'h120);
        wr(32'h120, 32'h0000_0004);
        @(negedge clk);

        // R2: poll with tx_on low is ignored
        pulse_poll();
        repeat (20) @(negedge clk);
        chk("R2 no request", req_cyc, 0);
        chk("R2 no byte", {31'd0, tx_valid}, 0);

        add_frame(32'h200, 6);
        add_frame(32'h206, 17);
        @(negedge clk) tx_on = 1'b1;
        pulse_poll();
        wait_unav(1);
        chk("R4 stream drained", exp_b.size(), 0);
        chk("R6 status d0", mem[32'h108 >> 2], 32'h0009_0006);
        chk("R6 flags d0", mem[32'h100 >> 2], 32'h0000_0014);
        chk("R6 status d1", mem[32'h118 >> 2], 32'h0008_0011);
        chk("R6 flags d1", mem[32'h110 >> 2], 32'h0000_0000);
        chk("R8 cpu desc untouched", mem[32'h120 >> 2], 32'h0000_0004);
        chk("R3 next pointer followed", cur_desc, 32'h120);
        chk("R8 cur_desc at halt", cur_desc, 32'h120);
        chk("R11 cur_buf", cur_buf, 32'h206);
        chk("R7 complete count", n_cmp, 2);
        chk("R7 summary count", n_sum, 2);
        chk("R8 unavail count", n_unav, 1);
        chk("R12 write transfers", n_wr, 4);

        // R9 resume same descriptor; R5 zero-length descriptor
        wr(32'h124, 32'h23F); wr(32'h128, 32'h0000_0005); wr(32'h12C, 32'h130);
        wr(32'h130, 32'h8000_0000); wr(32'h134, 32'h0); wr(32'h138, 32'h0); wr(32'h13C, 32'h140);
        wr(32'h140, 32'h0);
        wr(32'h120, 32'h8000_0004);
        @(negedge clk);
        add_frame(32'h23F, 5);
        pulse_poll();
        wait_unav(2);
        chk("R9 resumed desc status", mem[32'h128 >> 2], 32'h0009_0005);
        chk("R9 resumed desc flags", mem[32'h120 >> 2], 32'h0000_0004);
        chk("R5 zero-length status", mem[32'h138 >> 2], 32'h0008_0000);
        chk("R5 zero-length completes", n_cmp, 4);
        chk("R4 stream drained", exp_b.size(), 0);
        chk("R8 cur_desc at halt", cur_desc, 32'h140);
        chk("R11 cur_buf zero-length", cur_buf, 32'h0);
        chk("R12 write transfers", n_wr, 8);

        // R10: dropping tx_on while idle restarts at list_base
        @(negedge clk) tx_on = 1'b0;
        list_base = 32'h180;
        wr(32'h180, 32'h0);
        repeat (3) @(negedge clk);
        tx_on = 1'b1;
        pulse_poll();
        wait_unav(3);
        chk("R10 restart at list base", cur_desc, 32'h180);
        chk("R10 no completion", n_cmp, 4);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule